// File: doc/BRIEF.md
# Set/Clear Programmed Interrupt Controller

This block gathers 32 interrupt inputs into two request lines and one wake line. Each input has its own trigger mode: rising edge, falling edge, both edges, high level or low level. A 3-bit mode code per input selects the trigger. An edge is caught in a sticky latch and stays there until software clears it. A level trigger follows the synchronized input directly. Each input has a mask bit that gates it onto the request lines, a route bit that picks which request line it drives, and a wake bit that puts it on the wake line.

Software reaches the block through a single-cycle port. The address holds a 4-bit register index in `addr[5:2]` and a 2-bit operation in `addr[1:0]`. Operation 0 reads, 1 sets, 2 clears and 3 loads a whole word. A set or clear only touches the bit positions where the write data holds 1. Because every programmable register can be read back, a saved image can be restored by clearing a register with all ones and then setting the saved bits. A larger system places a second instance for sources 32 to 63, where local bit n stands for global source n+32.

Top module: `irq_router`

## Requirements
- R1: After reset every register reads zero, and `irqReq0`, `irqReq1` and `wakeOut` are low.
- R2: The mode of source i is {mode2[i],mode1[i],mode0[i]}, held in register indices 2, 1 and 0. The codes are 001 rising, 010 falling, 011 both edges, 101 high level and 110 low level. The codes 000, 100 and 111 make the source inactive.
- R3: Register indices 0 to 6 are mode0, mode1, mode2, source-select, route, wake and mask. Operation 1 ORs the write data into the register and operation 2 clears the bits where the data is 1. Operation 0 returns the register on `rdData` in the same cycle.
- R4: A level-mode source is active while its synchronized input matches the selected level. The input reaches the outputs two clock edges after it changes.
- R5: A source whose route bit is 1 drives `irqReq0`. A source whose route bit is 0 drives `irqReq1`.
- R6: In an edge mode, a matching edge sets the rising latch (index 7) or the falling latch (index 8), and the source stays active while that latch is set. Writing 1 with operation 2 to index 7 or 8 clears the latch bit.
- R7: Read-only index 9 shows the active, masked-in sources routed to request 0, and index 10 shows those routed to request 1. Each request line is the OR of its pending register, so a masked-out source drives neither line.
- R8: When an edge and a latch-clear write hit the same bit in the same cycle, the latch bit ends up set.
- R9: `wakeOut` is the OR of active sources whose wake bit is 1. The mask bit does not affect it.
- R10: Index 11 is a test word written whole by operation 3 and read back by operation 0. The source-select register holds its value and has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe for a single cycle |
| addr | input | 6 | {register index, operation} |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for operation 0, zero otherwise |
| srcIn | input | 32 | Asynchronous interrupt inputs |
| irqReq0 | output | 1 | Combined request line 0 |
| irqReq1 | output | 1 | Combined request line 1 |
| wakeOut | output | 1 | Combined wake line |

## Verification
Two things can land on the same edge latch bit in one cycle: a newly detected edge, and a software write that clears the latch. The bench raises an input and counts the two synchronizer stages plus the edge-compare stage. It then places the clear write on exactly the edge where the latch sets. The check passes only if the bit reads back as set afterwards. A plain clear with no edge must then empty the bit, which shows that the clear path works and was only outranked by the edge.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int REG_IDX_W = 4;
  localparam int OP_W      = 2;
  localparam int ADDR_W    = REG_IDX_W + OP_W;
  localparam int NUM_CTL   = 7;

  localparam int IX_MODE0 = 0;
  localparam int IX_MODE1 = 1;
  localparam int IX_MODE2 = 2;
  localparam int IX_SRC   = 3;
  localparam int IX_ROUTE = 4;
  localparam int IX_WAKE  = 5;
  localparam int IX_MASK  = 6;
  localparam int IX_RISE  = 7;
  localparam int IX_FALL  = 8;
  localparam int IX_PEND0 = 9;
  localparam int IX_PEND1 = 10;
  localparam int IX_TEST  = 11;

  localparam logic [OP_W-1:0] OP_READ = 2'd0;
  localparam logic [OP_W-1:0] OP_SET  = 2'd1;
  localparam logic [OP_W-1:0] OP_CLR  = 2'd2;
  localparam logic [OP_W-1:0] OP_LOAD = 2'd3;

  localparam logic [2:0] MODE_RISE = 3'b001;
  localparam logic [2:0] MODE_FALL = 3'b010;
  localparam logic [2:0] MODE_BOTH = 3'b011;
  localparam logic [2:0] MODE_HIGH = 3'b101;
  localparam logic [2:0] MODE_LOW  = 3'b110;

  typedef struct packed {
    logic [REG_IDX_W-1:0] regIdx;
    logic                 rdEn;
    logic                 setEn;
    logic                 clrEn;
    logic                 loadEn;
  } strobe_t;
endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb
);
  logic [REG_IDX_W-1:0] idx;
  logic [OP_W-1:0]      op;
  logic                 isCtl;
  logic                 isLatch;

  assign idx     = addr[ADDR_W-1:OP_W];
  assign op      = addr[OP_W-1:0];
  assign isCtl   = idx < REG_IDX_W'(NUM_CTL);
  assign isLatch = (idx == REG_IDX_W'(IX_RISE)) || (idx == REG_IDX_W'(IX_FALL));

  always_comb begin
    stb.regIdx = idx;
    stb.rdEn   = (op == OP_READ);
    stb.setEn  = wrEn && (op == OP_SET) && isCtl;
    stb.clrEn  = wrEn && (op == OP_CLR) && (isCtl || isLatch);
    stb.loadEn = wrEn && (op == OP_LOAD) && (idx == REG_IDX_W'(IX_TEST));
  end

  always_comb begin
    assert_strobe_excl_R3: assert ($countones({stb.setEn, stb.clrEn, stb.loadEn}) <= 1)
      else $error("more than one write strobe");
  end
endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [NSRC-1:0] wrData,
  input  logic [NSRC-1:0] srcIn,
  output logic [NSRC-1:0] rdData,
  output logic            irqReq0,
  output logic            irqReq1,
  output logic            wakeOut
);
  logic [NSRC-1:0] ctlReg [NUM_CTL];
  logic [NSRC-1:0] syncA, syncB, syncPrev;
  logic [NSRC-1:0] riseLat, fallLat, testReg;
  logic [NSRC-1:0] riseArm, fallArm, lvlHi, lvlLo;
  logic [NSRC-1:0] riseHit, fallHit, riseClr, fallClr;
  logic [NSRC-1:0] active, pend0, pend1;

  for (genvar g = 0; g < NUM_CTL; g++) begin : gCtl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        ctlReg[g] <= '0;
      else if (stb.setEn && stb.regIdx == REG_IDX_W'(g))
        ctlReg[g] <= ctlReg[g] | wrData;
      else if (stb.clrEn && stb.regIdx == REG_IDX_W'(g))
        ctlReg[g] <= ctlReg[g] & ~wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
    end else begin
      syncA    <= srcIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  always_comb begin
    logic [2:0] mode;
    for (int i = 0; i < NSRC; i++) begin
      mode = {ctlReg[IX_MODE2][i], ctlReg[IX_MODE1][i], ctlReg[IX_MODE0][i]};
      riseArm[i] = (mode == MODE_RISE) || (mode == MODE_BOTH);
      fallArm[i] = (mode == MODE_FALL) || (mode == MODE_BOTH);
      lvlHi[i]   = (mode == MODE_HIGH);
      lvlLo[i]   = (mode == MODE_LOW);
    end
  end

  assign riseHit = syncB & ~syncPrev & riseArm;
  assign fallHit = ~syncB & syncPrev & fallArm;
  assign riseClr = (stb.clrEn && stb.regIdx == REG_IDX_W'(IX_RISE)) ? wrData : '0;
  assign fallClr = (stb.clrEn && stb.regIdx == REG_IDX_W'(IX_FALL)) ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseLat <= '0;
      fallLat <= '0;
      testReg <= '0;
    end else begin
      riseLat <= (riseLat & ~riseClr) | riseHit;
      fallLat <= (fallLat & ~fallClr) | fallHit;
      if (stb.loadEn) testReg <= wrData;
    end
  end

  assign active = (lvlHi & syncB) | (lvlLo & ~syncB)
                | (riseArm & riseLat) | (fallArm & fallLat);
  assign pend0  = active & ctlReg[IX_MASK] & ctlReg[IX_ROUTE];
  assign pend1  = active & ctlReg[IX_MASK] & ~ctlReg[IX_ROUTE];

  assign irqReq0 = |pend0;
  assign irqReq1 = |pend1;
  assign wakeOut = |(active & ctlReg[IX_WAKE]);

  always_comb begin
    rdData = '0;
    if (stb.rdEn) begin
      if (stb.regIdx < REG_IDX_W'(NUM_CTL))
        rdData = ctlReg[stb.regIdx[2:0]];
      else if (stb.regIdx == REG_IDX_W'(IX_RISE))  rdData = riseLat;
      else if (stb.regIdx == REG_IDX_W'(IX_FALL))  rdData = fallLat;
      else if (stb.regIdx == REG_IDX_W'(IX_PEND0)) rdData = pend0;
      else if (stb.regIdx == REG_IDX_W'(IX_PEND1)) rdData = pend1;
      else if (stb.regIdx == REG_IDX_W'(IX_TEST))  rdData = testReg;
    end
  end

  assert_set_sticks_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setEn && stb.regIdx == REG_IDX_W'(IX_MASK)) |=> (($past(wrData) & ~ctlReg[IX_MASK]) == '0))
    else $error("set bits missing from mask");

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((ctlReg[IX_MODE0] | ctlReg[IX_MODE1] | ctlReg[IX_MODE2]) == '0) |-> !(irqReq0 || irqReq1 || wakeOut))
    else $error("output from all-disabled sources");

  assert_route_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqReq0 |-> (ctlReg[IX_ROUTE] != '0))
    else $error("request 0 with nothing routed to it");

  assert_mask_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctlReg[IX_MASK] == '0) |-> !(irqReq0 || irqReq1))
    else $error("request while all masked");

  assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(riseHit) & ~riseLat) == '0))
    else $error("rising edge lost");
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSRC-1:0]   wrData,
  output logic [NSRC-1:0]   rdData,
  input  logic [NSRC-1:0]   srcIn,
  output logic              irqReq0,
  output logic              irqReq1,
  output logic              wakeOut
);
  strobe_t stb;

  irq_router_ctrl uCtrl (
    .wrEn (wrEn),
    .addr (addr),
    .stb  (stb)
  );

  irq_router_dp #(.NSRC(NSRC)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .srcIn   (srcIn),
    .rdData  (rdData),
    .irqReq0 (irqReq0),
    .irqReq1 (irqReq1),
    .wakeOut (wakeOut)
  );
endmodule

// File: tb/tb_irq_router.sv
`timescale 1ns/1ps
module tb_irq_router;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] srcIn = '0;
  logic        irqReq0, irqReq1, wakeOut;
  int vecs = 0;
  int fails = 0;
  bit done = 1'b0;

  irq_router dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .srcIn(srcIn), .irqReq0(irqReq0), .irqReq1(irqReq1),
    .wakeOut(wakeOut)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input int op, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = {4'(idx), 2'(op)}; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; addr = '0; wrData = '0;
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    addr = {4'(idx), 2'b00};
    #1;
    v = rdData;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit modelActive(input int m, input bit lvl, input bit rl, input bit fl);
    return (m == 5 && lvl) || (m == 6 && !lvl) ||
           ((m == 1 || m == 3) && rl) || ((m == 2 || m == 3) && fl);
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a, b, c;
    bit rl, fl;
    int s;
    waitc(3);
    rstN = 1'b1;
    waitc(1);

    // R1: reset state of every register and output
    for (int i = 0; i < 12; i++) begin
      rd(i, v);
      check("R1 reset read", v, 32'h0);
    end
    check("R1 reset outputs", {29'h0, irqReq0, irqReq1, wakeOut}, 32'h0);

    // R3: set/clear/readback on the seven programmable registers
    for (int i = 0; i < 7; i++) begin
      a = 32'h1357_9BDF * (i + 1);
      b = 32'h0F0F_00FF << i;
      c = 32'h3C3C_C3C3 ^ (32'h1 << (i * 4));
      wr(i, 1, a);
      wr(i, 1, b);
      wr(i, 2, c);
      rd(i, v);
      check("R3 set/clear readback", v, (a | b) & ~c);
      wr(i, 2, 32'hFFFF_FFFF);
      rd(i, v);
      check("R3 clear all", v, 32'h0);
    end

    // R2 R4 R6: sweep all eight mode codes through a low-high-low pulse
    wr(6, 1, 32'hFFFF_FFFF);
    wr(4, 1, 32'hFFFF_FFFF);
    for (int m = 0; m < 8; m++) begin
      s = m * 4 + 1;
      srcIn = '0;
      waitc(4);
      wr(7, 2, 32'hFFFF_FFFF);
      wr(8, 2, 32'hFFFF_FFFF);
      if (m[0]) wr(0, 1, 32'h1 << s);
      if (m[1]) wr(1, 1, 32'h1 << s);
      if (m[2]) wr(2, 1, 32'h1 << s);
      rl = 0; fl = 0;
      waitc(1);
      rd(9, v);
      check($sformatf("R2 R4 mode%0d idle pending", m), v, 32'(modelActive(m, 0, rl, fl)) << s);
      srcIn[s] = 1'b1;
      waitc(4);
      if (m == 1 || m == 3) rl = 1;
      rd(9, v);
      check($sformatf("R4 R6 mode%0d after rise pending", m), v, 32'(modelActive(m, 1, rl, fl)) << s);
      rd(7, v);
      check($sformatf("R6 mode%0d rise latch", m), v, 32'(rl) << s);
      check($sformatf("R7 mode%0d req0", m), {31'h0, irqReq0}, 32'(modelActive(m, 1, rl, fl)));
      srcIn[s] = 1'b0;
      waitc(4);
      if (m == 2 || m == 3) fl = 1;
      rd(9, v);
      check($sformatf("R4 R6 mode%0d after fall pending", m), v, 32'(modelActive(m, 0, rl, fl)) << s);
      rd(8, v);
      check($sformatf("R6 mode%0d fall latch", m), v, 32'(fl) << s);
      wr(0, 2, 32'hFFFF_FFFF);
      wr(1, 2, 32'hFFFF_FFFF);
      wr(2, 2, 32'hFFFF_FFFF);
    end
    // R6: latch clear by writing one at the clear operation
    wr(7, 2, 32'hFFFF_FFFF);
    wr(8, 2, 32'hFFFF_FFFF);
    rd(7, v); check("R6 rise latch cleared", v, 32'h0);
    rd(8, v); check("R6 fall latch cleared", v, 32'h0);

    // R5 R7 R9: routing, mask gating and wake
    wr(4, 2, 32'hFFFF_FFFF);
    wr(6, 2, 32'hFFFF_FFFF);
    wr(0, 1, 32'h4);
    wr(2, 1, 32'h4);
    wr(6, 1, 32'h4);
    srcIn = 32'h4;
    waitc(4);
    check("R5 route0 -> req1", {30'h0, irqReq0, irqReq1}, 32'h1);
    rd(10, v); check("R7 pend1", v, 32'h4);
    rd(9, v);  check("R7 pend0 empty", v, 32'h0);
    check("R9 wake off", {31'h0, wakeOut}, 32'h0);
    wr(4, 1, 32'h4);
    check("R5 route1 -> req0", {30'h0, irqReq0, irqReq1}, 32'h2);
    rd(9, v);  check("R7 pend0", v, 32'h4);
    wr(5, 1, 32'h4);
    wr(6, 2, 32'h4);
    check("R7 masked no req", {30'h0, irqReq0, irqReq1}, 32'h0);
    rd(9, v);  check("R7 masked pend0", v, 32'h0);
    check("R9 wake ignores mask", {31'h0, wakeOut}, 32'h1);
    srcIn = 32'h0;
    waitc(3);
    check("R9 wake follows level", {31'h0, wakeOut}, 32'h0);

    // R10: source register has no effect, test word load/readback
    wr(6, 1, 32'h4);
    srcIn = 32'h4;
    waitc(3);
    wr(3, 1, 32'hFFFF_FFFF);
    rd(3, v); check("R10 source readback", v, 32'hFFFF_FFFF);
    check("R10 source no effect", {29'h0, irqReq0, irqReq1, wakeOut}, 32'h5);
    wr(3, 2, 32'hFFFF_FFFF);
    check("R10 source no effect after clear", {29'h0, irqReq0, irqReq1, wakeOut}, 32'h5);
    wr(11, 3, 32'hA5A5_5A5A);
    rd(11, v); check("R10 test load", v, 32'hA5A5_5A5A);
    wr(11, 3, 32'h0);
    rd(11, v); check("R10 test zero", v, 32'h0);

    // R8: edge and latch clear on the same clock edge
    srcIn = 32'h0;
    wr(0, 2, 32'hFFFF_FFFF);
    wr(2, 2, 32'hFFFF_FFFF);
    wr(0, 1, 32'h200);
    waitc(4);
    wr(7, 2, 32'hFFFF_FFFF);
    rd(7, v); check("R8 pre-cleared", v, 32'h0);
    @(negedge clk);
    srcIn[9] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wrEn = 1'b1; addr = {4'(7), 2'd2}; wrData = 32'h200;
    @(negedge clk);
    wrEn = 1'b0; addr = '0; wrData = '0;
    rd(7, v); check("R8 edge beats clear", v, 32'h200);
    wr(7, 2, 32'h200);
    rd(7, v); check("R6 plain clear after race", v, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule